// File: doc/BRIEF.md
# Exception return status unit

This block computes the processor state that a return from an exception handler or a return from a non-maskable interrupt handler produces. It takes the current status word, the current stack pointer and the saved user stack pointer, along with a two-bit command. On a return command it restores the flag context that was pushed on entry. To do that it shifts the low 28-bit field of the status word right by ten places and keeps the two top bits unchanged. It then adjusts the pending and mask flags. If the restored context is user mode, it also swaps stacks: the current stack pointer becomes the kernel stack pointer and the user stack pointer becomes the live one.

All three results are registered. The new status word, stack pointer and kernel stack pointer appear one clock after the command is presented. When no return command is present the registers keep their contents. The pipeline reads the outputs as the architectural values.

Top module: `ers_unit`

## Requirements
- R1: A synchronous reset (rst_n low at a rising clock edge) clears status_o, sp_o and ksp_o to zero.
- R2: Command encoding on cmd_i: 2'b00 is idle, 2'b01 is return-from-exception, 2'b10 is return-from-NMI, and 2'b11 is reserved. Under idle or reserved, status_o, sp_o and ksp_o keep their values.
- R3: On either return command, the new status keeps bits 31:30 of status_i. Bits 17:0 become status_i bits 27:10 and bits 29:18 become zero, except for the flag updates of R4 and R5.
- R4: On either return command, bit 7 of the new status (pending flag) is forced to 1 when bit 8 of status_i (restart flag) is 0. Otherwise bit 7 takes the shifted value, which is status_i bit 17.
- R5: On return-from-NMI, bit 9 of the new status (mask flag) is always 1. On return-from-exception it takes the shifted value, which is status_i bit 19.
- R6: On a return command where bit 6 of the new status (user flag, status_i bit 16) is 1, ksp_o becomes sp_i and sp_o becomes usp_i.
- R7: On a return command where the new user flag is 0, sp_o becomes sp_i and ksp_o keeps its value.
- R8: Every update completes in one clock: all outputs reflect a command at the first rising edge after it is presented.
- R9: The restart-flag test of R4 uses status_i before the shift. The bit that lands on bit 8 after the shift (status_i bit 18) has no influence on bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 2 | Return command (R2 encoding) |
| status_i | input | 32 | Current status word |
| sp_i | input | 32 | Current stack pointer |
| usp_i | input | 32 | Saved user stack pointer |
| status_o | output | 32 | Registered new status word |
| sp_o | output | 32 | Registered new stack pointer |
| ksp_o | output | 32 | Registered kernel stack pointer |

## Verification
The sweep sets the restart flag, the user flag, the bit that shifts onto the restart position and the two preserved top bits in all combinations, under all four commands.

Each combination targets a specific mistake:
- A design that tests the restart flag after the shift would get the pending flag wrong whenever status bit 18 differs from bit 8.
- A design that clears the top bits, or shifts them along with the field, would corrupt bits 31:30 or leave garbage in the gap.
- Treating the reserved code as a return would change the outputs when they should hold.
- Swapping stacks on the wrong flag, or writing the kernel pointer when the context is not user mode, shows up as a stale or wrong ksp_o or sp_o.

// File: rtl/ers_pkg.sv
// Shared types for the exception return status unit.
package ers_pkg;

    // Two-bit return command; code 2'b11 is reserved and acts as idle.
    typedef enum logic [1:0] {
        ERS_IDLE    = 2'b00,
        ERS_RET_EXC = 2'b01,
        ERS_RET_NMI = 2'b10,
        ERS_RSVD    = 2'b11
    } ers_cmd_e;

    // Decoded command: whether to update, and whether the mask flag is forced.
    typedef struct packed {
        logic active;
        logic is_nmi;
    } ers_op_t;

endpackage

// File: rtl/ers_cmd_decode.sv
// Command decoder.
// Turns the raw two-bit command into an update enable and an NMI marker.
// Assumes the reserved code must behave exactly like idle.
module ers_cmd_decode
    import ers_pkg::*;
(
    input  logic [1:0] cmd_i,
    output ers_op_t    op_o
);

    // Map each command code to its decoded operation.
    always_comb begin
        op_o = '{active: 1'b0, is_nmi: 1'b0};
        case (ers_cmd_e'(cmd_i))
            ERS_RET_EXC: op_o = '{active: 1'b1, is_nmi: 1'b0};
            ERS_RET_NMI: op_o = '{active: 1'b1, is_nmi: 1'b1};
            default:     op_o = '{active: 1'b0, is_nmi: 1'b0};
        endcase
    end

endmodule

// File: rtl/ers_status_pop.sv
// Status context pop.
// Keeps the top KEEP_W bits, shifts the low FIELD_W bits right by SHIFT and
// clears everything in between. It then applies the pending-flag and
// mask-flag rules. The restart flag is sampled from the unshifted word.
// Purely combinational; the caller registers the result.
module ers_status_pop #(
    parameter int W       = 32,
    parameter int KEEP_W  = 2,
    parameter int FIELD_W = 28,
    parameter int SHIFT   = 10,
    parameter int U_POS   = 6,
    parameter int P_POS   = 7,
    parameter int R_POS   = 8,
    parameter int M_POS   = 9
) (
    input  logic [W-1:0] status_i,
    input  logic         is_nmi_i,
    output logic [W-1:0] status_o,
    output logic         user_o
);

    localparam logic [W-1:0] ONES       = {W{1'b1}};
    localparam logic [W-1:0] KEEP_MASK  = ~(ONES >> KEEP_W);
    localparam logic [W-1:0] FIELD_MASK = ONES >> (W - FIELD_W);

    logic [W-1:0] popped;

    // Build the shifted context with the preserved top bits.
    always_comb begin
        popped = (status_i & KEEP_MASK) | ((status_i & FIELD_MASK) >> SHIFT);
    end

    // The user flag is taken from the shifted value, before any flag forcing.
    always_comb begin
        user_o = popped[U_POS];
    end

    // Apply the pending and mask flag rules on top of the popped word.
    always_comb begin
        status_o = popped;
        if (!status_i[R_POS]) begin
            status_o[P_POS] = 1'b1;
        end
        if (is_nmi_i) begin
            status_o[M_POS] = 1'b1;
        end
    end

endmodule

// File: rtl/ers_stack_swap.sv
// Stack pointer selection.
// When the restored context is user mode, the live pointer is saved as the
// kernel pointer and the user pointer becomes live. Otherwise the live
// pointer passes through and the kernel pointer holds its value.
module ers_stack_swap #(
    parameter int W = 32
) (
    input  logic         user_i,
    input  logic [W-1:0] sp_i,
    input  logic [W-1:0] usp_i,
    input  logic [W-1:0] ksp_cur_i,
    output logic [W-1:0] sp_next_o,
    output logic [W-1:0] ksp_next_o
);

    // Choose the next live and kernel stack pointers.
    always_comb begin
        if (user_i) begin
            sp_next_o  = usp_i;
            ksp_next_o = sp_i;
        end else begin
            sp_next_o  = sp_i;
            ksp_next_o = ksp_cur_i;
        end
    end

endmodule

// File: rtl/ers_unit.sv
// Exception return status unit (top).
// Registers the popped status word and the selected stack pointers whenever
// a return command is present. Reset is synchronous and active low and
// clears all three registers. Idle and reserved commands hold state.
module ers_unit #(
    parameter int W       = 32,
    parameter int KEEP_W  = 2,
    parameter int FIELD_W = 28,
    parameter int SHIFT   = 10,
    parameter int U_POS   = 6,
    parameter int P_POS   = 7,
    parameter int R_POS   = 8,
    parameter int M_POS   = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   cmd_i,
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] sp_i,
    input  logic [W-1:0] usp_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] sp_o,
    output logic [W-1:0] ksp_o
);
    import ers_pkg::*;

    ers_op_t      op;
    logic [W-1:0] status_next;
    logic         user_next;
    logic [W-1:0] sp_next;
    logic [W-1:0] ksp_next;
    logic [W-1:0] status_q;
    logic [W-1:0] sp_q;
    logic [W-1:0] ksp_q;

    ers_cmd_decode u_decode (
        .cmd_i (cmd_i),
        .op_o  (op)
    );

    ers_status_pop #(
        .W       (W),
        .KEEP_W  (KEEP_W),
        .FIELD_W (FIELD_W),
        .SHIFT   (SHIFT),
        .U_POS   (U_POS),
        .P_POS   (P_POS),
        .R_POS   (R_POS),
        .M_POS   (M_POS)
    ) u_pop (
        .status_i (status_i),
        .is_nmi_i (op.is_nmi),
        .status_o (status_next),
        .user_o   (user_next)
    );

    ers_stack_swap #(
        .W (W)
    ) u_swap (
        .user_i     (user_next),
        .sp_i       (sp_i),
        .usp_i      (usp_i),
        .ksp_cur_i  (ksp_q),
        .sp_next_o  (sp_next),
        .ksp_next_o (ksp_next)
    );

    // State registers: clear on reset, load on a return command, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            sp_q     <= '0;
            ksp_q    <= '0;
        end else if (op.active) begin
            status_q <= status_next;
            sp_q     <= sp_next;
            ksp_q    <= ksp_next;
        end
    end

    assign status_o = status_q;
    assign sp_o     = sp_q;
    assign ksp_o    = ksp_q;

endmodule

// File: rtl/ers_unit_chk.sv
// Property checker for ers_unit, attached through bind.
// Observes only the ports of the top module.
module ers_unit_chk #(
    parameter int W       = 32,
    parameter int KEEP_W  = 2,
    parameter int FIELD_W = 28,
    parameter int SHIFT   = 10,
    parameter int U_POS   = 6,
    parameter int P_POS   = 7,
    parameter int R_POS   = 8,
    parameter int M_POS   = 9
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   cmd_i,
    input logic [W-1:0] status_i,
    input logic [W-1:0] sp_i,
    input logic [W-1:0] usp_i,
    input logic [W-1:0] status_o,
    input logic [W-1:0] sp_o,
    input logic [W-1:0] ksp_o
);

    localparam logic [W-1:0] ONES       = {W{1'b1}};
    localparam logic [W-1:0] KEEP_MASK  = ~(ONES >> KEEP_W);
    localparam logic [W-1:0] LOW_MASK   = (ONES >> (W - FIELD_W)) >> SHIFT;
    localparam logic [W-1:0] FLAG_MASK  = (W'(1) << P_POS) | (W'(1) << M_POS);
    localparam logic [W-1:0] GAP_MASK   = ~(KEEP_MASK | LOW_MASK | FLAG_MASK);

    logic ret_cmd;
    logic ret_nmi;

    // Classify the observed command.
    always_comb begin
        ret_cmd = (cmd_i == 2'b01) || (cmd_i == 2'b10);
        ret_nmi = (cmd_i == 2'b10);
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (status_o == '0 && sp_o == '0 && ksp_o == '0));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_cmd |=> ($stable(status_o) && $stable(sp_o) && $stable(ksp_o)));

    assert_keep_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ret_cmd |=> ((status_o & KEEP_MASK) == ($past(status_i) & KEEP_MASK)));

    assert_gap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ret_cmd |=> ((status_o & GAP_MASK) == '0));

    assert_pending_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_cmd && !status_i[R_POS]) |=> status_o[P_POS]);

    assert_mask_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ret_nmi |=> status_o[M_POS]);

    assert_user_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ret_cmd ##1 status_o[U_POS] |-> (ksp_o == $past(sp_i) && sp_o == $past(usp_i)));

    assert_kernel_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ret_cmd ##1 !status_o[U_POS] |-> (sp_o == $past(sp_i) && $stable(ksp_o)));

endmodule

bind ers_unit ers_unit_chk #(
    .W       (W),
    .KEEP_W  (KEEP_W),
    .FIELD_W (FIELD_W),
    .SHIFT   (SHIFT),
    .U_POS   (U_POS),
    .P_POS   (P_POS),
    .R_POS   (R_POS),
    .M_POS   (M_POS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_i    (cmd_i),
    .status_i (status_i),
    .sp_i     (sp_i),
    .usp_i    (usp_i),
    .status_o (status_o),
    .sp_o     (sp_o),
    .ksp_o    (ksp_o)
);

// File: tb/ers_unit_tb_top.sv
// Sweep bench for ers_unit with its default 32-bit configuration.
module ers_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cmd_i;
    logic [31:0] status_i;
    logic [31:0] sp_i;
    logic [31:0] usp_i;
    logic [31:0] status_o;
    logic [31:0] sp_o;
    logic [31:0] ksp_o;

    int          n_checks = 0;
    int          n_fails  = 0;
    logic [31:0] rng      = 32'h1D87_2B41;
    logic [31:0] m_status = '0;
    logic [31:0] m_sp     = '0;
    logic [31:0] m_ksp    = '0;

    ers_unit dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (cmd_i),
        .status_i (status_i),
        .sp_i     (sp_i),
        .usp_i    (usp_i),
        .status_o (status_o),
        .sp_o     (sp_o),
        .ksp_o    (ksp_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Drive one vector at a falling edge, update the model, check at the next falling edge.
    task automatic step(input logic [1:0] c, input logic [31:0] st,
                        input logic [31:0] sp, input logic [31:0] usp);
        logic [31:0] pop;
        logic [31:0] prev_status;
        logic [31:0] prev_sp;
        logic [31:0] prev_ksp;
        prev_status = m_status;
        prev_sp     = m_sp;
        prev_ksp    = m_ksp;
        cmd_i    = c;
        status_i = st;
        sp_i     = sp;
        usp_i    = usp;
        if (c == 2'b01 || c == 2'b10) begin
            pop = (st & 32'hC000_0000) | ((st & 32'h0FFF_FFFF) / 1024);
            if (pop[6]) begin
                m_ksp = sp;
                m_sp  = usp;
            end else begin
                m_sp  = sp;
            end
            if (st[8] == 1'b0) pop = pop | 32'h0000_0080;
            if (c == 2'b10)    pop = pop | 32'h0000_0200;
            m_status = pop;
        end
        @(negedge clk);
        if (c == 2'b00 || c == 2'b11) begin
            check("R2 status hold", status_o, prev_status);
            check("R2 sp hold", sp_o, prev_sp);
            check("R2 ksp hold", ksp_o, prev_ksp);
        end else begin
            check("R3 R8 status", status_o, m_status);
            check("R4 pending bit", {31'd0, status_o[7]}, {31'd0, m_status[7]});
            if (st[18] != st[8])
                check("R9 pre-shift restart test", {31'd0, status_o[7]}, {31'd0, m_status[7]});
            check("R5 mask bit", {31'd0, status_o[9]}, {31'd0, m_status[9]});
            if (m_status[6]) begin
                check("R6 sp from user", sp_o, m_sp);
                check("R6 ksp saved", ksp_o, m_ksp);
            end else begin
                check("R7 sp pass", sp_o, m_sp);
                check("R7 ksp held", ksp_o, m_ksp);
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cmd_i = 2'b10;
        status_i = 32'hFFFF_FFFF;
        sp_i = 32'hAAAA_5555;
        usp_i = 32'h5555_AAAA;
        @(negedge clk);
        m_status = '0;
        m_sp     = '0;
        m_ksp    = '0;
        check("R1 status reset", status_o, 32'h0);
        check("R1 sp reset", sp_o, 32'h0);
        check("R1 ksp reset", ksp_o, 32'h0);
        rst_n = 1'b1;
        cmd_i = 2'b00;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cmd_i = 2'b00;
        status_i = '0;
        sp_i = '0;
        usp_i = '0;
        @(negedge clk);
        do_reset();

        // Directed: restart flag clear, user flag set, return from NMI.
        step(2'b10, 32'h8001_0000, 32'h0000_1000, 32'h0000_2000);
        check("R6 directed status", status_o, 32'h8000_02C0);

        // Sweep: every command against every combination of six key status bits.
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 64; k++) begin
                logic [31:0] st;
                logic [31:0] sp;
                logic [31:0] usp;
                next_rand();
                st = rng;
                next_rand();
                sp = rng;
                next_rand();
                usp = rng;
                st[8]  = k[0];
                st[16] = k[1];
                st[18] = k[2];
                st[31] = k[3];
                st[30] = k[4];
                st[17] = k[5];
                step(c[1:0], st, sp, usp);
            end
        end

        // Reserved code after a known state must hold outputs.
        step(2'b01, 32'h4000_0100, 32'h1111_0000, 32'h2222_0000);
        step(2'b11, 32'hFFFF_FFFF, 32'h3333_0000, 32'h4444_0000);

        // Reset in the middle of traffic.
        do_reset();
        step(2'b01, 32'h0000_0000, 32'h0BAD_0000, 32'h0CAB_0000);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule